// File: doc/BRIEF.md
# Random Generator Control and Status Registers

This block is the software-visible register front end of a random number generator. It sits on a simple 32-bit register bus and steers an external entropy and conditioning datapath. That datapath is outside the block. It hands over 32-bit words with a one-cycle valid strobe, and it reports clock and seed faults on two level inputs.

The block holds the following state:
- a control register whose configuration can be frozen for good by a one-way lock bit;
- a status register with live and sticky fault bits;
- a one-word data holding register with a ready flag;
- a health-test configuration register, which is reached only after a key value is written to its own address.

A single registered interrupt output combines data-ready and the two sticky fault flags, gated by an enable bit.

Bus reads are registered. `bus_rdata` carries the read value in the cycle after `bus_rd` is sampled high. Writes take effect at the clock edge that samples `bus_wr`.

Top module: `rng_regs`

## Requirements
- R1: After synchronous reset, the control, status and data registers read 0, the irq output is 0, and the health-test register holds the parameter HT_RESET.
- R2: Control register layout (offset 0x00):
  - bit0 generator enable
  - bit1 interrupt enable
  - bit2 clock-detect off (0 means detection on)
  - bit3 custom mode (0 means the compliant default)
  - bit4 conditioning soft reset
  - bits 10:5 cfg_a (6 bits), bits 13:11 cfg_b (3 bits), bits 17:14 cfg_c (4 bits)
  - bits 21:18 divider code, where code n means 2^n source clocks per internal clock
  - bit31 lock
  
  Unused bits read 0. Each field is driven on its matching output port.
- R3: The lock bit is set by writing 1 and cannot be cleared except by reset. While lock is set, writes leave bits 21:5, bit3 and bit2 unchanged; bits 0, 1 and 4 stay writable. A write that sets lock also updates the fields in that same write.
- R4: A write to the health-test register (offset 0x10) loads the configuration only if the previous bus access was a write of the key 0x17590ABC to that same address. Any other write there is ignored.
- R5: A read of the health-test register returns its value only if the previous bus access was a key write to that address, and returns 0 otherwise. A read, or any other access, consumes the key.
- R6: While the generator is enabled, ready is clear and soft reset is off, a word with ent_valid is captured and ready (status bit0) is set. Words arriving while ready is set are dropped.
- R7: A read of the data register (offset 0x08) returns the held word and clears ready.
- R8: While soft reset (control bit4) is set, ready and the held word are cleared and incoming words are discarded.
- R9: Sticky clock-fault (status bit5) and seed-fault (status bit6) are set while the matching fault input is high. Writing 0 to a sticky bit at offset 0x04 clears it; writing 1 leaves it unchanged.
- R10: Status bit1 shows the live clock fault and bit2 shows the live seed fault, each with one cycle of register delay. While clock detection is off, the clock fault sets neither bit1 nor bit5.
- R11: irq is registered and equals interrupt-enable AND (ready OR sticky clock-fault OR sticky seed-fault), one cycle after those register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ent_valid | input | 1 | Datapath word strobe |
| ent_word | input | 32 | Datapath word |
| clk_err_in | input | 1 | Live clock fault from the detector |
| seed_err_in | input | 1 | Live seed fault from the source |
| gen_en | output | 1 | Generator enable |
| clkdet_off | output | 1 | Clock-fault detection disabled |
| custom_mode | output | 1 | Custom (non-default) compliance setting |
| cond_rst | output | 1 | Conditioning soft reset |
| cfg_a | output | 6 | Configuration field A |
| cfg_b | output | 3 | Configuration field B |
| cfg_c | output | 4 | Configuration field C |
| div_code | output | 4 | Clock divider code |
| health_cfg | output | 32 | Health-test configuration |
| irq | output | 1 | Combined interrupt |

## Verification
The health-test path is driven with four kinds of sequence:
- a key followed by a write;
- a bare write;
- a key separated from its write by another access;
- a key followed by a read, then a repeated read.

Together these separate "previous access was the key" from "a key was seen at some time".

The data path is fed words with ready both clear and set, and with soft reset held, so that capture, drop and flush can be told apart. The fault inputs are pulsed with detection on and off. Clear-by-zero writes are tried with both all-ones and all-zeros data. The lock is exercised last: a locked write of new enable bits must change only those bits.

// File: rtl/rng_regs_pkg.sv
package rng_regs_pkg;
  localparam int DW = 32;
  localparam logic [31:0] HT_KEY = 32'h1759_0ABC;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_DATA = 'h08;
  localparam int OFS_HT   = 'h10;

  localparam int CA_W = 6;
  localparam int CB_W = 3;
  localparam int CC_W = 4;
  localparam int DV_W = 4;

  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_CDO  = 2;
  localparam int B_CUST = 3;
  localparam int B_CRST = 4;
  localparam int B_CA   = 5;
  localparam int B_CB   = B_CA + CA_W;
  localparam int B_CC   = B_CB + CB_W;
  localparam int B_DV   = B_CC + CC_W;
  localparam int B_LOCK = 31;

  localparam int S_RDY = 0;
  localparam int S_CLK = 1;
  localparam int S_SEED = 2;
  localparam int S_CLKS = 5;
  localparam int S_SEEDS = 6;

  typedef struct packed {
    logic            lock;
    logic [DV_W-1:0] div;
    logic [CC_W-1:0] cc;
    logic [CB_W-1:0] cb;
    logic [CA_W-1:0] ca;
    logic            crst;
    logic            cust;
    logic            cdo;
    logic            ie;
    logic            en;
  } ctrl_t;

  function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
    logic [DW-1:0] v;
    v = '0;
    v[B_EN]   = c.en;
    v[B_IE]   = c.ie;
    v[B_CDO]  = c.cdo;
    v[B_CUST] = c.cust;
    v[B_CRST] = c.crst;
    v[B_CA +: CA_W] = c.ca;
    v[B_CB +: CB_W] = c.cb;
    v[B_CC +: CC_W] = c.cc;
    v[B_DV +: DV_W] = c.div;
    v[B_LOCK] = c.lock;
    return v;
  endfunction
endpackage

// File: rtl/rng_ctrl_reg.sv
module rng_ctrl_reg
  import rng_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr) begin
      ctrl.en   <= wdata[B_EN];
      ctrl.ie   <= wdata[B_IE];
      ctrl.crst <= wdata[B_CRST];
      if (wdata[B_LOCK]) ctrl.lock <= 1'b1;
      if (!ctrl.lock) begin
        ctrl.cdo  <= wdata[B_CDO];
        ctrl.cust <= wdata[B_CUST];
        ctrl.ca   <= wdata[B_CA +: CA_W];
        ctrl.cb   <= wdata[B_CB +: CB_W];
        ctrl.cc   <= wdata[B_CC +: CC_W];
        ctrl.div  <= wdata[B_DV +: DV_W];
      end
    end
  end
endmodule

// File: rtl/rng_data_hold.sv
module rng_data_hold
  import rng_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          flush,
  input  logic          take,
  input  logic          in_valid,
  input  logic [DW-1:0] in_word,
  output logic          ready,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ready <= 1'b0;
      word  <= '0;
    end else if (!ready && enable && in_valid) begin
      ready <= 1'b1;
      word  <= in_word;
    end else if (take) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_status_flags.sv
module rng_status_flags
  import rng_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_err,
  input  logic          seed_err,
  input  logic          det_off,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          clk_now,
  output logic          seed_now,
  output logic          clk_sticky,
  output logic          seed_sticky
);
  logic clk_eff;
  assign clk_eff = clk_err & ~det_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_now     <= 1'b0;
      seed_now    <= 1'b0;
      clk_sticky  <= 1'b0;
      seed_sticky <= 1'b0;
    end else begin
      clk_now  <= clk_eff;
      seed_now <= seed_err;
      if (clk_eff) clk_sticky <= 1'b1;
      else if (wr && !wdata[S_CLKS]) clk_sticky <= 1'b0;
      if (seed_err) seed_sticky <= 1'b1;
      else if (wr && !wdata[S_SEEDS]) seed_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_health_reg.sv
module rng_health_reg
  import rng_regs_pkg::*;
#(
  parameter logic [DW-1:0] RESET_VAL = 32'h0000_6A5C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_wr,
  input  logic          hit_rd,
  input  logic          other_acc,
  input  logic [DW-1:0] wdata,
  output logic          armed,
  output logic [DW-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cfg   <= RESET_VAL;
    end else if (hit_wr) begin
      if (armed) begin
        cfg   <= wdata;
        armed <= 1'b0;
      end else begin
        armed <= (wdata == HT_KEY);
      end
    end else if (hit_rd || other_acc) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_regs.sv
module rng_regs
  import rng_regs_pkg::*;
#(
  parameter int              ADDR_W  = 5,
  parameter logic [DW-1:0]   HT_RESET = 32'h0000_6A5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ent_valid,
  input  logic [DW-1:0]     ent_word,
  input  logic              clk_err_in,
  input  logic              seed_err_in,
  output logic              gen_en,
  output logic              clkdet_off,
  output logic              custom_mode,
  output logic              cond_rst,
  output logic [CA_W-1:0]   cfg_a,
  output logic [CB_W-1:0]   cfg_b,
  output logic [CC_W-1:0]   cfg_c,
  output logic [DV_W-1:0]   div_code,
  output logic [DW-1:0]     health_cfg,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_HT   = ADDR_W'(OFS_HT);

  logic sel_ctrl, sel_stat, sel_data, sel_ht;
  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_stat = (bus_addr == A_STAT);
  assign sel_data = (bus_addr == A_DATA);
  assign sel_ht   = (bus_addr == A_HT);

  ctrl_t ctrl;
  logic ready, clk_now, seed_now, clk_sticky, seed_sticky, ht_armed;
  logic [DW-1:0] word;

  rng_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr && sel_ctrl), .wdata(bus_wdata), .ctrl(ctrl)
  );

  rng_data_hold u_hold (
    .clk(clk), .rst(rst), .enable(ctrl.en), .flush(ctrl.crst),
    .take(bus_rd && sel_data), .in_valid(ent_valid), .in_word(ent_word),
    .ready(ready), .word(word)
  );

  rng_status_flags u_stat (
    .clk(clk), .rst(rst), .clk_err(clk_err_in), .seed_err(seed_err_in),
    .det_off(ctrl.cdo), .wr(bus_wr && sel_stat), .wdata(bus_wdata),
    .clk_now(clk_now), .seed_now(seed_now),
    .clk_sticky(clk_sticky), .seed_sticky(seed_sticky)
  );

  rng_health_reg #(.RESET_VAL(HT_RESET)) u_ht (
    .clk(clk), .rst(rst),
    .hit_wr(bus_wr && sel_ht), .hit_rd(bus_rd && sel_ht),
    .other_acc((bus_wr || bus_rd) && !sel_ht),
    .wdata(bus_wdata), .armed(ht_armed), .cfg(health_cfg)
  );

  logic [DW-1:0] stat_word, rd_mux;
  always_comb begin
    stat_word = '0;
    stat_word[S_RDY]   = ready;
    stat_word[S_CLK]   = clk_now;
    stat_word[S_SEED]  = seed_now;
    stat_word[S_CLKS]  = clk_sticky;
    stat_word[S_SEEDS] = seed_sticky;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux = pack_ctrl(ctrl);
    else if (sel_stat) rd_mux = stat_word;
    else if (sel_data) rd_mux = word;
    else if (sel_ht && ht_armed) rd_mux = health_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= ctrl.ie & (ready | clk_sticky | seed_sticky);
    end
  end

  assign gen_en      = ctrl.en;
  assign clkdet_off  = ctrl.cdo;
  assign custom_mode = ctrl.cust;
  assign cond_rst    = ctrl.crst;
  assign cfg_a       = ctrl.ca;
  assign cfg_b       = ctrl.cb;
  assign cfg_c       = ctrl.cc;
  assign div_code    = ctrl.div;
endmodule

// File: rtl/rng_regs_chk.sv
module rng_regs_chk
  import rng_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     health_cfg,
  input logic              ht_armed,
  input logic              lock,
  input logic              ready,
  input logic              cond_rst,
  input logic [CA_W-1:0]   cfg_a,
  input logic [DV_W-1:0]   div_code,
  input logic              irq,
  input logic              ie
);
  p_lock_holds_r3: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(cfg_a) && $stable(div_code)));
  p_ht_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_HT) && !ht_armed) |=> $stable(health_cfg));
  p_ht_hidden_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_HT) && !ht_armed) |=> (bus_rdata == '0));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_DATA) && ready) |=> !ready);
  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    cond_rst |=> !ready);
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

bind rng_regs rng_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .health_cfg(health_cfg), .ht_armed(ht_armed),
  .lock(ctrl.lock), .ready(ready), .cond_rst(cond_rst), .cfg_a(cfg_a),
  .div_code(div_code), .irq(irq), .ie(ctrl.ie)
);

// File: tb/sim_rng_regs.sv
module sim_rng_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam logic [31:0] HT_RST = 32'h0000_6A5C;
  localparam logic [31:0] KEY = 32'h1759_0ABC;
  localparam logic [AW-1:0] AC = 5'h00, AS = 5'h04, AD = 5'h08, AH = 5'h10;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ent_valid = 0, clk_err_in = 0, seed_err_in = 0;
  logic [31:0] ent_word = '0;
  logic gen_en, clkdet_off, custom_mode, cond_rst, irq;
  logic [5:0] cfg_a; logic [2:0] cfg_b; logic [3:0] cfg_c, div_code;
  logic [31:0] health_cfg;

  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_regs #(.ADDR_W(AW), .HT_RESET(HT_RST)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_valid(ent_valid),
    .ent_word(ent_word), .clk_err_in(clk_err_in), .seed_err_in(seed_err_in),
    .gen_en(gen_en), .clkdet_off(clkdet_off), .custom_mode(custom_mode),
    .cond_rst(cond_rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .div_code(div_code), .health_cfg(health_cfg), .irq(irq)
  );

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, AC, 32'h0, 8'd1},
    '{1'b1, AS, 32'h0, 8'd1},
    '{1'b1, AD, 32'h0, 8'd1},
    '{1'b1, AH, 32'h0, 8'd5},
    '{1'b0, AH, KEY, 8'd5},
    '{1'b1, AH, HT_RST, 8'd1},
    '{1'b1, AH, 32'h0, 8'd5},
    '{1'b0, AH, 32'h0000_1234, 8'd4},
    '{1'b0, AH, KEY, 8'd4},
    '{1'b1, AH, HT_RST, 8'd4},
    '{1'b0, AH, KEY, 8'd4},
    '{1'b0, AH, 32'hCAFE_0001, 8'd4},
    '{1'b0, AH, KEY, 8'd4},
    '{1'b1, AH, 32'hCAFE_0001, 8'd4},
    '{1'b0, AH, KEY, 8'd4},
    '{1'b0, AC, 32'h0, 8'd4},
    '{1'b0, AH, 32'hDEAD_0000, 8'd4},
    '{1'b0, AH, KEY, 8'd4},
    '{1'b1, AH, 32'hCAFE_0001, 8'd4},
    '{1'b0, AC, 32'h7FFF_FFEF, 8'd2},
    '{1'b1, AC, 32'h003F_FFEF, 8'd2},
    '{1'b0, AC, 32'h0, 8'd2}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rdchk(input logic [AW-1:0] a, input logic [31:0] e, input string rq);
    logic [31:0] d;
    rd(a, d);
    check(rq, d, e);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); ent_valid = 1; ent_word = w;
    @(negedge clk); ent_valid = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 health_cfg", health_cfg, HT_RST);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rdchk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i));
      else wr(VEC[i].addr, VEC[i].data);
    end
    check("R4 health_cfg port", health_cfg, 32'hCAFE_0001);

    // R6 / R7 capture, drop, read
    wr(AC, 32'h1);
    push(32'hA5A5_0001);
    rdchk(AS, 32'h1, "R6 ready set");
    push(32'hB0B0_0002);
    rdchk(AD, 32'hA5A5_0001, "R6 drop while ready / R7 data");
    rdchk(AS, 32'h0, "R7 ready cleared");
    push(32'hC3C3_0003);
    rdchk(AD, 32'hC3C3_0003, "R6 second capture");

    // R8 soft reset
    push(32'hD4D4_0004);
    wr(AC, 32'h11);
    push(32'hE5E5_0005);
    rdchk(AS, 32'h0, "R8 ready flushed");
    rdchk(AD, 32'h0, "R8 word flushed");
    wr(AC, 32'h1);
    rdchk(AS, 32'h0, "R8 discarded input");

    // R9 / R10 faults
    @(negedge clk); clk_err_in = 1;
    rdchk(AS, 32'h22, "R10 live clk + R9 sticky");
    @(negedge clk); clk_err_in = 0;
    @(negedge clk);
    rdchk(AS, 32'h20, "R9 sticky held");
    wr(AS, 32'hFFFF_FFFF);
    rdchk(AS, 32'h20, "R9 write 1 keeps");
    wr(AS, 32'h0);
    rdchk(AS, 32'h0, "R9 write 0 clears");
    @(negedge clk); seed_err_in = 1;
    rdchk(AS, 32'h44, "R10 live seed");
    @(negedge clk); seed_err_in = 0;
    @(negedge clk);
    wr(AS, 32'hFFFF_FFBF);
    rdchk(AS, 32'h0, "R9 seed cleared");
    wr(AC, 32'h5);
    @(negedge clk); clk_err_in = 1;
    rdchk(AS, 32'h0, "R10 masked when detect off");
    @(negedge clk); clk_err_in = 0;

    // R11 irq
    wr(AC, 32'h1);
    @(negedge clk); seed_err_in = 1;
    @(negedge clk); seed_err_in = 0;
    @(negedge clk);
    check("R11 irq gated off", {31'b0, irq}, 32'h0);
    wr(AC, 32'h3);
    @(negedge clk);
    check("R11 irq on sticky", {31'b0, irq}, 32'h1);
    wr(AS, 32'h0);
    @(negedge clk);
    check("R11 irq after clear", {31'b0, irq}, 32'h0);
    push(32'h1111_2222);
    @(negedge clk);
    check("R11 irq on ready", {31'b0, irq}, 32'h1);
    rdchk(AD, 32'h1111_2222, "R7 data for irq");
    @(negedge clk);
    check("R11 irq after read", {31'b0, irq}, 32'h0);

    // R3 lock
    wr(AC, 32'h8025_5D4C);
    check("R2 div port", {28'b0, div_code}, 32'h9);
    check("R2 cfg_a port", {26'b0, cfg_a}, 32'h2A);
    wr(AC, 32'h0000_0003);
    rdchk(AC, 32'h8025_5D4F, "R3 locked fields kept");
    check("R3 gen_en writable", {31'b0, gen_en}, 32'h1);
    wr(AC, 32'h0);
    rdchk(AC, 32'h8025_5D4C, "R3 lock not clearable");

    // R1 reset releases lock
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rdchk(AC, 32'h0, "R1 ctrl after reset");
    check("R1 health after reset", health_cfg, HT_RST);

    finish_run();
  end
endmodule